// File: doc/BRIEF.md
# Interlaced Field Scanout Sequencer

This block produces the read-address stream that feeds an interlaced standard-definition video port from a progressive framebuffer of 16-bit pixels. Each frame is split into two fields that are woven out of the one buffer. Field 1 takes the even buffer lines and field 2 takes the odd ones. The block walks a ring of four segments: the blanking lines of field 1, the active lines of field 1, the blanking lines of field 2, and the active lines of field 2. Blanking lines read one fixed dummy location. Active lines read consecutive pixels, and each new line skips the line that belongs to the other field.

A two-bit mode input selects the geometry. Bit 0 picks the line structure: 0 for the 525-line standard, 1 for the 625-line standard. Bit 1 picks the active width: 0 for the full width, 1 for the narrow width. The framebuffer base address and a vertical pan offset, counted in lines, set where the active fields start reading. All three inputs are taken only when a frame begins, so one frame never mixes two settings.

Each sample is a read request with a valid/ready handshake towards memory. Along with it the block gives a blank flag, a line-start pulse and a field marker. An error input stops scanout and restarts it cleanly, beginning again with the active lines of field 2.

Top module: `field_scanout`

## Requirements
- R1: The segments follow the ring blank-1, active-1, blank-2, active-2, then back to blank-1. After reset, and after every error restart, the first request is line 0 of the active-2 segment.
- R2: With mode bit 1 low, the segment line counts are 22, 240, 23 and 240 for mode bit 0 = 0, and 24, 288, 25 and 288 for mode bit 0 = 1 (parameter defaults). Mode 3 (narrow width, 625-line) moves 20 lines out of each active segment into the blanking segment before it.
- R3: Every line, blank or active, carries the active width plus a per-standard pre-transition blank count of samples. The defaults are a width of 720 with blank counts of 16 (525-line) and 12 (625-line). The narrow width of 640 adds 40 more blank samples.
- R4: In both blanking segments every request has the blank flag set and carries the fixed dummy address.
- R5: With line length L = 2 x active width bytes, sample p of line k of active field 1 is at base + pan x L + 2kL + 2p. Active field 2 adds L to this.
- R6: The mode, base and pan inputs are sampled only on entry to the blank-1 segment and on a restart. A change at any other time first takes effect in the next frame.
- R7: While a request is valid and ready is low, the request is held unchanged, and no sample is skipped or repeated.
- R8: A cycle with the error input high makes valid low in the next cycle. Scanout then restarts one cycle later, with the inputs sampled at that point.
- R9: The field marker is 0 in the field-1 segments and 1 in the field-2 segments, toggling on entry to each blanking segment. The line-start output is high on the first sample of each line.
- R10: During reset, valid and line-start are low and the field marker is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bit 0: 625-line standard; bit 1: narrow width |
| base_i | input | ADDR_W | Framebuffer base byte address |
| pan_i | input | PAN_W | Vertical pan offset in lines |
| err_i | input | 1 | Error (e.g. underrun): stop and restart |
| rd_ready_i | input | 1 | Memory accepts the current request |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_blank_o | output | 1 | Sample belongs to a blanking segment |
| line_start_o | output | 1 | First sample of a line |
| field_o | output | 1 | Field marker (0 = field 1, 1 = field 2) |

## Verification
Assertions check some rules on every cycle:
- the ring order and the restart into active field 2;
- the dummy address during blanking;
- the frozen request while ready is low;
- valid dropping after an error;
- pan and base changing only at frame entry;
- the field marker changing only at blanking entry;
- the fixed address steps within and between active lines.

Other behaviour only the bench scenarios can show: the exact per-mode line and sample counts of every segment, the woven addresses across whole frames, and a pan change made mid-frame first reaching the following frame. The bench shows these by comparing every cycle against an independent model and by counting the samples of each segment.

// File: rtl/fscan_pkg.sv
package fscan_pkg;

    // Width of every geometry count (samples per line, lines, line bytes).
    localparam int unsigned GEOM_W = 12;

    // Ring positions; the ring advances by incrementing this code.
    typedef enum logic [1:0] {
        SEG_VB1 = 2'd0,
        SEG_AV1 = 2'd1,
        SEG_VB2 = 2'd2,
        SEG_AV2 = 2'd3
    } seg_e;

    typedef struct packed {
        logic [GEOM_W-1:0] spl;        // samples per line
        logic [GEOM_W-1:0] vb1_lines;
        logic [GEOM_W-1:0] act_lines;
        logic [GEOM_W-1:0] vb2_lines;
        logic [GEOM_W-1:0] line_bytes;
    } geom_t;

    function automatic logic seg_is_blank(seg_e s);
        return (s == SEG_VB1) || (s == SEG_VB2);
    endfunction

endpackage

// File: rtl/fscan_geom.sv
module fscan_geom
    import fscan_pkg::*;
#(
    parameter int unsigned PIX_FULL    = 720,
    parameter int unsigned PIX_NARROW  = 640,
    parameter int unsigned PRE_525     = 16,
    parameter int unsigned PRE_625     = 12,
    parameter int unsigned NARROW_XTRA = 40,
    parameter int unsigned VB1_525     = 22,
    parameter int unsigned ACT_525     = 240,
    parameter int unsigned VB2_525     = 23,
    parameter int unsigned VB1_625     = 24,
    parameter int unsigned ACT_625     = 288,
    parameter int unsigned VB2_625     = 25,
    parameter int unsigned NARROW_MOVE = 20
) (
    input  logic [1:0] mode_i,
    output geom_t      geom_o
);

    localparam logic [GEOM_W-1:0] W_FULL   = GEOM_W'(PIX_FULL);
    localparam logic [GEOM_W-1:0] W_NARROW = GEOM_W'(PIX_NARROW);
    localparam logic [GEOM_W-1:0] P_525    = GEOM_W'(PRE_525);
    localparam logic [GEOM_W-1:0] P_625    = GEOM_W'(PRE_625);
    localparam logic [GEOM_W-1:0] P_XTRA   = GEOM_W'(NARROW_XTRA);
    localparam logic [GEOM_W-1:0] L_VB1_A  = GEOM_W'(VB1_525);
    localparam logic [GEOM_W-1:0] L_ACT_A  = GEOM_W'(ACT_525);
    localparam logic [GEOM_W-1:0] L_VB2_A  = GEOM_W'(VB2_525);
    localparam logic [GEOM_W-1:0] L_VB1_B  = GEOM_W'(VB1_625);
    localparam logic [GEOM_W-1:0] L_ACT_B  = GEOM_W'(ACT_625);
    localparam logic [GEOM_W-1:0] L_VB2_B  = GEOM_W'(VB2_625);
    localparam logic [GEOM_W-1:0] L_MOVE   = GEOM_W'(NARROW_MOVE);

    logic              is_625;
    logic              is_narrow;
    logic [GEOM_W-1:0] act_w;
    logic [GEOM_W-1:0] pre_w;
    logic [GEOM_W-1:0] moved;

    always_comb begin
        is_625    = mode_i[0];
        is_narrow = mode_i[1];
        act_w     = is_narrow ? W_NARROW : W_FULL;
        pre_w     = (is_625 ? P_625 : P_525) + (is_narrow ? P_XTRA : '0);
        moved     = (is_625 && is_narrow) ? L_MOVE : '0;

        geom_o.spl        = act_w + pre_w;
        geom_o.line_bytes = {act_w[GEOM_W-2:0], 1'b0};
        geom_o.vb1_lines  = (is_625 ? L_VB1_B : L_VB1_A) + moved;
        geom_o.act_lines  = is_625 ? (L_ACT_B - moved) : L_ACT_A;
        geom_o.vb2_lines  = (is_625 ? L_VB2_B : L_VB2_A) + moved;
    end

endmodule

// File: rtl/fscan_seq.sv
module fscan_seq
    import fscan_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PAN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic              ready_i,
    input  geom_t             geom_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [PAN_W-1:0]  pan_i,
    output logic              run_o,
    output seg_e              seg_o,
    output seg_e              seg_nxt_o,
    output logic              line_start_o,
    output logic              field_o,
    output logic              step_o,
    output logic              enter_o,
    output logic              new_line_o,
    output logic [GEOM_W-1:0] lbytes_o,
    output logic [GEOM_W-1:0] lbytes_nxt_o,
    output logic [ADDR_W-1:0] base_nxt_o,
    output logic [PAN_W-1:0]  pan_nxt_o
);

    localparam logic [GEOM_W-1:0] ONE = GEOM_W'(1);

    typedef struct packed {
        logic              run;
        seg_e              seg;
        logic [GEOM_W-1:0] pix;
        logic [GEOM_W-1:0] line;
        logic              field;
        geom_t             geom;
        logic [ADDR_W-1:0] base;
        logic [PAN_W-1:0]  pan;
    } st_t;

    st_t               st_d, st_q;
    logic [GEOM_W-1:0] seg_lines;
    logic              last_pix, last_line;
    seg_e              seg_inc;
    logic              step_d, enter_d, nline_d;

    always_comb begin
        case (st_q.seg)
            SEG_VB1: seg_lines = st_q.geom.vb1_lines;
            SEG_VB2: seg_lines = st_q.geom.vb2_lines;
            default: seg_lines = st_q.geom.act_lines;
        endcase
        last_pix  = (st_q.pix == st_q.geom.spl - ONE);
        last_line = (st_q.line == seg_lines - ONE);
        seg_inc   = seg_e'(st_q.seg + 2'd1);

        st_d    = st_q;
        step_d  = 1'b0;
        enter_d = 1'b0;
        nline_d = 1'b0;

        if (err_i) begin
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            // restart: reload the ring head (active field 2) and the frame settings
            st_d.run   = 1'b1;
            st_d.seg   = SEG_AV2;
            st_d.pix   = '0;
            st_d.line  = '0;
            st_d.field = 1'b1;
            st_d.geom  = geom_i;
            st_d.base  = base_i;
            st_d.pan   = pan_i;
            enter_d    = 1'b1;
        end else if (ready_i) begin
            step_d = 1'b1;
            if (!last_pix) begin
                st_d.pix = st_q.pix + ONE;
            end else begin
                st_d.pix = '0;
                if (!last_line) begin
                    st_d.line = st_q.line + ONE;
                    nline_d   = 1'b1;
                end else begin
                    st_d.line = '0;
                    st_d.seg  = seg_inc;
                    enter_d   = 1'b1;
                    if (seg_inc == SEG_VB1) begin
                        st_d.geom = geom_i;
                        st_d.base = base_i;
                        st_d.pan  = pan_i;
                    end
                    if (seg_is_blank(seg_inc)) begin
                        st_d.field = ~st_q.field;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.seg   <= SEG_AV2;
            st_q.field <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o        = st_q.run;
    assign seg_o        = st_q.seg;
    assign seg_nxt_o    = st_d.seg;
    assign line_start_o = st_q.run && (st_q.pix == '0);
    assign field_o      = st_q.field;
    assign step_o       = step_d;
    assign enter_o      = enter_d;
    assign new_line_o   = nline_d;
    assign lbytes_o     = st_q.geom.line_bytes;
    assign lbytes_nxt_o = st_d.geom.line_bytes;
    assign base_nxt_o   = st_d.base;
    assign pan_nxt_o    = st_d.pan;

    // R1: while running, a segment change always moves one step forward on the ring
    p_ring_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && $past(st_q.run) && (st_q.seg != $past(st_q.seg))
        |-> st_q.seg == seg_e'($past(st_q.seg) + 2'd1));

    // R6: frame settings change only at the first sample of blank field 1
    p_pan_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && $past(st_q.run)
        && ((st_q.pan != $past(st_q.pan)) || (st_q.base != $past(st_q.base)))
        |-> (st_q.seg == SEG_VB1) && (st_q.line == '0) && (st_q.pix == '0));

    // R9: the field marker flips only when a blanking segment begins
    p_field_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && $past(st_q.run) && (st_q.field != $past(st_q.field))
        |-> seg_is_blank(st_q.seg) && (st_q.line == '0) && (st_q.pix == '0));

endmodule

// File: rtl/fscan_addr.sv
module fscan_addr
    import fscan_pkg::*;
#(
    parameter int unsigned         ADDR_W     = 32,
    parameter int unsigned         PAN_W      = 10,
    parameter logic [ADDR_W-1:0]   DUMMY_ADDR = 32'hFF80_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              enter_i,
    input  logic              new_line_i,
    input  seg_e              seg_q_i,
    input  seg_e              seg_d_i,
    input  logic [GEOM_W-1:0] lbytes_q_i,
    input  logic [GEOM_W-1:0] lbytes_d_i,
    input  logic [ADDR_W-1:0] base_d_i,
    input  logic [PAN_W-1:0]  pan_d_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] PIX_BYTES = ADDR_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] lstart;
    } ast_t;

    ast_t              a_d, a_q;
    logic [ADDR_W-1:0] pan_off;
    logic [ADDR_W-1:0] fld_start;
    logic [ADDR_W-1:0] skip_q;

    always_comb begin
        pan_off   = ADDR_W'(pan_d_i) * ADDR_W'(lbytes_d_i);
        fld_start = base_d_i + pan_off
                  + ((seg_d_i == SEG_AV2) ? ADDR_W'(lbytes_d_i) : '0);
        skip_q    = ADDR_W'({lbytes_q_i, 1'b0});

        a_d = a_q;
        if (enter_i) begin
            if (seg_is_blank(seg_d_i)) begin
                a_d.addr   = DUMMY_ADDR;
                a_d.lstart = DUMMY_ADDR;
            end else begin
                a_d.addr   = fld_start;
                a_d.lstart = fld_start;
            end
        end else if (new_line_i) begin
            if (!seg_is_blank(seg_q_i)) begin
                // skip the interleaved line that belongs to the other field
                a_d.lstart = a_q.lstart + skip_q;
                a_d.addr   = a_q.lstart + skip_q;
            end
        end else if (step_i && !seg_is_blank(seg_q_i)) begin
            a_d.addr = a_q.addr + PIX_BYTES;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.addr   <= DUMMY_ADDR;
            a_q.lstart <= DUMMY_ADDR;
        end else begin
            a_q <= a_d;
        end
    end

    assign addr_o = a_q.addr;

    // R5: within an active line each accepted sample moves on by one pixel
    p_pixel_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !enter_i && !new_line_i && !seg_is_blank(seg_q_i)
        |=> addr_o == $past(addr_o) + PIX_BYTES);

    // R5: a new active line begins two line lengths after the previous one
    p_line_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        new_line_i && !seg_is_blank(seg_q_i)
        |=> addr_o == $past(a_q.lstart) + $past(skip_q));

endmodule

// File: rtl/field_scanout.sv
module field_scanout
    import fscan_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       PAN_W       = 10,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR  = 32'hFF80_0000,
    parameter int unsigned       PIX_FULL    = 720,
    parameter int unsigned       PIX_NARROW  = 640,
    parameter int unsigned       PRE_525     = 16,
    parameter int unsigned       PRE_625     = 12,
    parameter int unsigned       NARROW_XTRA = 40,
    parameter int unsigned       VB1_525     = 22,
    parameter int unsigned       ACT_525     = 240,
    parameter int unsigned       VB2_525     = 23,
    parameter int unsigned       VB1_625     = 24,
    parameter int unsigned       ACT_625     = 288,
    parameter int unsigned       VB2_625     = 25,
    parameter int unsigned       NARROW_MOVE = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [PAN_W-1:0]  pan_i,
    input  logic              err_i,
    input  logic              rd_ready_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_blank_o,
    output logic              line_start_o,
    output logic              field_o
);

    geom_t             geom_in;
    seg_e              seg_q, seg_d;
    logic              step, enter, new_line;
    logic [GEOM_W-1:0] lbytes_q, lbytes_d;
    logic [ADDR_W-1:0] base_d;
    logic [PAN_W-1:0]  pan_d;

    fscan_geom #(
        .PIX_FULL(PIX_FULL), .PIX_NARROW(PIX_NARROW),
        .PRE_525(PRE_525), .PRE_625(PRE_625), .NARROW_XTRA(NARROW_XTRA),
        .VB1_525(VB1_525), .ACT_525(ACT_525), .VB2_525(VB2_525),
        .VB1_625(VB1_625), .ACT_625(ACT_625), .VB2_625(VB2_625),
        .NARROW_MOVE(NARROW_MOVE)
    ) geom_i (
        .mode_i (mode_i),
        .geom_o (geom_in)
    );

    fscan_seq #(.ADDR_W(ADDR_W), .PAN_W(PAN_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_i        (err_i),
        .ready_i      (rd_ready_i),
        .geom_i       (geom_in),
        .base_i       (base_i),
        .pan_i        (pan_i),
        .run_o        (rd_valid_o),
        .seg_o        (seg_q),
        .seg_nxt_o    (seg_d),
        .line_start_o (line_start_o),
        .field_o      (field_o),
        .step_o       (step),
        .enter_o      (enter),
        .new_line_o   (new_line),
        .lbytes_o     (lbytes_q),
        .lbytes_nxt_o (lbytes_d),
        .base_nxt_o   (base_d),
        .pan_nxt_o    (pan_d)
    );

    fscan_addr #(.ADDR_W(ADDR_W), .PAN_W(PAN_W), .DUMMY_ADDR(DUMMY_ADDR)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .enter_i    (enter),
        .new_line_i (new_line),
        .seg_q_i    (seg_q),
        .seg_d_i    (seg_d),
        .lbytes_q_i (lbytes_q),
        .lbytes_d_i (lbytes_d),
        .base_d_i   (base_d),
        .pan_d_i    (pan_d),
        .addr_o     (rd_addr_o)
    );

    assign rd_blank_o = seg_is_blank(seg_q);

    // R4: blanking requests always carry the dummy source address
    p_blank_dummy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && rd_blank_o |-> rd_addr_o == DUMMY_ADDR);

    // R7: a stalled request stays exactly as it was
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i && !err_i
        |=> rd_valid_o && $stable(rd_addr_o) && $stable(line_start_o)
            && $stable(field_o) && $stable(rd_blank_o));

    // R8: an error withdraws the request in the next cycle
    p_err_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> !rd_valid_o);

    // R1: scanout always (re)starts on the first line of active field 2
    p_restart_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> !rd_blank_o && line_start_o && field_o);

endmodule

// File: tb/field_scanout_tb.sv
module field_scanout_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    // Shrunk geometry so that many whole frames fit in a short run
    localparam int PF  = 8;
    localparam int PN  = 6;
    localparam int NPR = 2;
    localparam int PPR = 3;
    localparam int EXT = 1;
    localparam int NV1 = 2;
    localparam int NA  = 4;
    localparam int NV2 = 3;
    localparam int PV1 = 3;
    localparam int PA  = 5;
    localparam int PV2 = 4;
    localparam int MV  = 1;
    localparam logic [31:0] DUMMY = 32'hFF80_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] base = 32'h0000_1000;
    logic [9:0]  pan = 10'd0;
    logic        err = 1'b0;
    logic        rd_ready = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_blank;
    logic        rd_line_start;
    logic        rd_field;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    field_scanout #(
        .ADDR_W(32), .PAN_W(10), .DUMMY_ADDR(DUMMY),
        .PIX_FULL(PF), .PIX_NARROW(PN), .PRE_525(NPR), .PRE_625(PPR),
        .NARROW_XTRA(EXT), .VB1_525(NV1), .ACT_525(NA), .VB2_525(NV2),
        .VB1_625(PV1), .ACT_625(PA), .VB2_625(PV2), .NARROW_MOVE(MV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .base_i(base), .pan_i(pan),
        .err_i(err), .rd_ready_i(rd_ready), .rd_valid_o(rd_valid),
        .rd_addr_o(rd_addr), .rd_blank_o(rd_blank),
        .line_start_o(rd_line_start), .field_o(rd_field)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int b_width(int m);
        return ((m & 2) != 0) ? PN : PF;
    endfunction

    function automatic int b_spl(int m);
        return b_width(m) + (((m & 1) != 0) ? PPR : NPR) + (((m & 2) != 0) ? EXT : 0);
    endfunction

    function automatic int b_lines(int m, int s);
        int mv;
        bit p;
        p  = (m & 1) != 0;
        mv = (m == 3) ? MV : 0;
        case (s)
            0:       return p ? PV1 + mv : NV1;
            2:       return p ? PV2 + mv : NV2;
            default: return p ? PA - mv : NA;
        endcase
    endfunction

    // behavioural model state
    bit          m_run = 1'b0;
    int          m_seg = 3;
    int          m_ln = 0;
    int          m_px = 0;
    bit          m_fld = 1'b1;
    int          m_mode = 0;
    longint      m_base = 0;
    longint      m_pan = 0;

    function automatic logic [31:0] exp_addr();
        longint lb;
        longint a;
        if ((m_seg % 2) == 0) return DUMMY;
        lb = 2 * b_width(m_mode);
        a  = m_base + m_pan * lb + ((m_seg == 3) ? lb : 0) + m_ln * 2 * lb + m_px * 2;
        return a[31:0];
    endfunction

    // segment accounting from the outputs alone
    bit          seg_open = 1'b0;
    logic [1:0]  cur_key = 2'b00;
    int          cnt_s = 0;
    int          cnt_l = 0;
    int          seg_mode = 0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    task automatic close_seg();
        int s;
        int lines;
        case (cur_key)
            2'b01:   s = 0;
            2'b00:   s = 1;
            2'b11:   s = 2;
            default: s = 3;
        endcase
        lines = b_lines(seg_mode, s);
        chk(cnt_l == lines, "R2 segment line count", cnt_l, lines);
        chk(cnt_s == lines * b_spl(seg_mode), "R3 segment sample count",
            cnt_s, lines * b_spl(seg_mode));
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 1'b0;
            m_fld = 1'b1;
            seg_open = 1'b0;
            prev_stall = 1'b0;
        end else begin
            prev_stall = rd_valid && !rd_ready && !err;
            prev_addr  = rd_addr;
            if (err) begin
                seg_open = 1'b0;
            end else if (rd_valid && rd_ready) begin
                if (!seg_open || ({rd_field, rd_blank} != cur_key)) begin
                    if (seg_open) close_seg();
                    seg_open = 1'b1;
                    cur_key  = {rd_field, rd_blank};
                    cnt_s    = 0;
                    cnt_l    = 0;
                    seg_mode = m_mode;
                end
                cnt_s++;
                if (rd_line_start) cnt_l++;
            end
            // model step
            if (err) begin
                m_run = 1'b0;
            end else if (!m_run) begin
                m_run  = 1'b1;
                m_seg  = 3;
                m_ln   = 0;
                m_px   = 0;
                m_fld  = 1'b1;
                m_mode = int'(mode);
                m_base = longint'(base);
                m_pan  = longint'(pan);
            end else if (rd_ready) begin
                m_px++;
                if (m_px == b_spl(m_mode)) begin
                    m_px = 0;
                    m_ln++;
                    if (m_ln == b_lines(m_mode, m_seg)) begin
                        m_ln  = 0;
                        m_seg = (m_seg + 1) % 4;
                        if (m_seg == 0) begin
                            m_mode = int'(mode);
                            m_base = longint'(base);
                            m_pan  = longint'(pan);
                        end
                        if ((m_seg % 2) == 0) m_fld = ~m_fld;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_valid == m_run, "R8 request valid", rd_valid, m_run);
            if (m_run && rd_valid) begin
                chk(rd_addr == exp_addr(),
                    ((m_seg % 2) == 0) ? "R4 blank address" : "R5 active address",
                    rd_addr, exp_addr());
                chk(rd_blank == ((m_seg % 2) == 0), "R4 blank flag", rd_blank, (m_seg % 2) == 0);
                chk(rd_line_start == (m_px == 0), "R9 line start", rd_line_start, m_px == 0);
                chk(rd_field == m_fld, "R9 field marker", rd_field, m_fld);
                chk((m_seg != 0) || (m_ln != 0) || (m_px != 0) || rd_blank,
                    "R1 ring head", rd_blank, 1);
            end
            if (prev_stall) chk(rd_addr == prev_addr, "R7 stall hold", rd_addr, prev_addr);
        end
    end

    task automatic wait_first(input bit f, input bit b);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rd_valid && rd_field == f && rd_blank == b && rd_line_start) return;
        end
        chk(1'b0, "R1 segment never reached", {f, b}, 0);
    endtask

    task automatic run_cycles(input int n, input bit rand_ready);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
        end
        @(negedge clk);
        rd_ready = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(rd_valid == 1'b0, "R10 valid in reset", rd_valid, 0);
        chk(rd_field == 1'b1, "R10 field in reset", rd_field, 1);
        chk(rd_line_start == 1'b0, "R10 line start in reset", rd_line_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first request is line 0 of active field 2 (525-line full width, L = 16)
        chk(rd_valid && !rd_blank && rd_field && rd_line_start, "R1 start segment",
            {rd_valid, rd_blank, rd_field}, 3'b101);
        chk(rd_addr == 32'h0000_1010, "R1 start address", rd_addr, 32'h0000_1010);

        run_cycles(400, 1'b0);
        run_cycles(400, 1'b1);

        // R6: change settings while in active field 1; next active field 2 keeps old ones
        wait_first(1'b0, 1'b0);
        mode = 2'd1;
        base = 32'h0000_2000;
        pan  = 10'd3;
        wait_first(1'b1, 1'b1);
        wait_first(1'b1, 1'b0);
        chk(rd_addr == 32'h0000_1010, "R6 old frame settings", rd_addr, 32'h0000_1010);
        wait_first(1'b0, 1'b0);
        chk(rd_addr == 32'h0000_2030, "R6 new frame settings", rd_addr, 32'h0000_2030);

        run_cycles(500, 1'b1);
        mode = 2'd2;
        run_cycles(600, 1'b1);
        mode = 2'd3;
        pan  = 10'd2;
        run_cycles(700, 1'b1);

        // R8: error mid-frame, then restart at active field 2 with current inputs
        wait_first(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        base = 32'h0000_4000;
        err  = 1'b1;
        @(negedge clk);
        err  = 1'b0;
        chk(rd_valid == 1'b0, "R8 valid drop after error", rd_valid, 0);
        @(negedge clk);
        // mode 3: width 6 -> L = 12; pan 2 -> start = 0x4000 + 24 + 12
        chk(rd_valid && !rd_blank && rd_field && rd_line_start, "R8 restart segment",
            {rd_valid, rd_blank, rd_field}, 3'b101);
        chk(rd_addr == 32'h0000_4024, "R8 restart address", rd_addr, 32'h0000_4024);

        run_cycles(400, 1'b1);
        mode = 2'd0;
        pan  = 10'd0;
        run_cycles(400, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        done = 1'b1;
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        summary();
        $finish;
    end

endmodule